// File: doc/BRIEF.md
# Macro Engine ALU with Carry Flag

This block is the arithmetic and logic stage of a small command-processing macro engine. Each instruction presents two 32-bit operands and a 5-bit operation code, and the result is available in the same cycle through combinational logic. A single carry flag is held in a register. It feeds the carry-consuming add and subtract operations. It is updated only on a clock edge where the engine commits the instruction by raising the enable.

Arithmetic codes produce a carry that means "carry out" for additions and "no borrow" for subtractions. So a chain of subtract-with-borrow steps works across wide words, just as a chain of add-with-carry steps does. Logic codes never touch the flag. Codes outside the supported set drive a zero result. They also pulse an error strobe and leave the flag alone. A synchronous clear resets the flag at the start of each macro run.

Top module: `mac_alu`

## Requirements
- R1: Code 0 (add) drives y = (a + b) mod 2^32. When enabled, the next carry is 1 exactly when a + b > 0xFFFFFFFF.
- R2: Code 1 (add with carry) drives y = (a + b + carry) mod 2^32. When enabled, the next carry is 1 exactly when a + b + carry > 0xFFFFFFFF.
- R3: Code 2 (subtract) drives y = (a - b) mod 2^32. When enabled, the next carry is 1 exactly when a >= b.
- R4: Code 3 (subtract with borrow) drives y = (a - b - (carry ? 0 : 1)) mod 2^32. When enabled, the next carry is 1 exactly when a >= b + (carry ? 0 : 1).
- R5: The logic codes drive these results: 8 gives a XOR b, 9 gives a OR b, 10 gives a AND b, 11 gives a AND NOT b, and 12 gives NOT (a AND b).
- R6: Logic codes 8 to 12 leave the carry flag unchanged, even when enabled.
- R7: Every other code (4 to 7 and 13 to 31) drives y = 0 and leaves the carry unchanged. The bad_op output is 1 in each cycle where such a code is presented with en high. Otherwise bad_op is 0.
- R8: The carry changes only on a rising clock edge with en high or clr high. With both low, the carry holds.
- R9: A high clr at a rising edge sets the carry to 0, and clr takes priority over en. An active-low rst_n also sets the carry to 0.
- R10: The values of y and bad_op follow the inputs within the same cycle, with no register in their path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous carry clear, start of macro run |
| en | input | 1 | Commit instruction; allows carry update |
| op | input | 5 | Operation code |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| y | output | 32 | Combinational result |
| carry | output | 1 | Current carry flag |
| bad_op | output | 1 | Unsupported-code strobe |

## Verification
The bench aims first at the flag's polarity in subtraction. Equal operands must give carry 1 and a zero result. A design that treated carry as "borrow" would flip every subtract flag, and subtract-with-borrow would then be off by one. The bench also drives subtract-with-borrow with the flag both clear and set, and add-with-carry at the 0xFFFFFFFF wrap, so a design that injected the flag with the wrong sense would show up. It checks that logic codes, the holes at codes 4 to 7, and cycles with en low all leave the flag unchanged. Finally, clr is raised together with en, which exposes a design that lets the commit win over the clear.

// File: rtl/mac_alu_pkg.sv
package mac_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBB  = 5'd3,
        OP_XOR  = 5'd8,
        OP_OR   = 5'd9,
        OP_AND  = 5'd10,
        OP_ANDN = 5'd11,
        OP_NAND = 5'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_BAD   = 2'd2
    } op_class_e;

    typedef enum logic [2:0] {
        LG_XOR  = 3'd0,
        LG_OR   = 3'd1,
        LG_AND  = 3'd2,
        LG_ANDN = 3'd3,
        LG_NAND = 3'd4
    } logic_fn_e;

    typedef struct packed {
        op_class_e cls;
        logic      invert_b;   // subtract: add ones' complement of b
        logic      use_carry;  // inject flag as carry-in
        logic      const_in;   // fixed carry-in when flag not used
        logic_fn_e lfn;
    } dec_t;

endpackage

// File: rtl/mac_alu_dec.sv
module mac_alu_dec
    import mac_alu_pkg::*;
(
    input  logic [4:0] op,
    output dec_t       dec
);
    always_comb begin
        dec = '{cls: CLS_BAD, invert_b: 1'b0, use_carry: 1'b0,
                const_in: 1'b0, lfn: LG_XOR};
        case (op)
            OP_ADD:  dec.cls = CLS_ARITH;
            OP_ADC:  begin dec.cls = CLS_ARITH; dec.use_carry = 1'b1; end
            OP_SUB:  begin dec.cls = CLS_ARITH; dec.invert_b = 1'b1; dec.const_in = 1'b1; end
            OP_SBB:  begin dec.cls = CLS_ARITH; dec.invert_b = 1'b1; dec.use_carry = 1'b1; end
            OP_XOR:  begin dec.cls = CLS_LOGIC; dec.lfn = LG_XOR;  end
            OP_OR:   begin dec.cls = CLS_LOGIC; dec.lfn = LG_OR;   end
            OP_AND:  begin dec.cls = CLS_LOGIC; dec.lfn = LG_AND;  end
            OP_ANDN: begin dec.cls = CLS_LOGIC; dec.lfn = LG_ANDN; end
            OP_NAND: begin dec.cls = CLS_LOGIC; dec.lfn = LG_NAND; end
            default: dec.cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/mac_alu_arith.sv
module mac_alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int SW = W + 1;

    logic [W-1:0]  b_eff;
    logic [SW-1:0] total;

    // Subtraction as a + ~b + cin: cout is then "no borrow".
    always_comb begin
        b_eff = invert_b ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/mac_alu_logic.sv
module mac_alu_logic
    import mac_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    lfn,
    output logic [W-1:0] res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (lfn)
                LG_XOR:  res[i] = a[i] ^ b[i];
                LG_OR:   res[i] = a[i] | b[i];
                LG_AND:  res[i] = a[i] & b[i];
                LG_ANDN: res[i] = a[i] & ~b[i];
                LG_NAND: res[i] = ~(a[i] & b[i]);
                default: res[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         carry,
    output logic         bad_op
);
    typedef struct packed {
        logic carry;
    } state_t;

    state_t       st_d, st_q;
    dec_t         dec;
    logic [W-1:0] arith_sum;
    logic [W-1:0] logic_res;
    logic         arith_cout;
    logic         cin;

    mac_alu_dec u_dec (
        .op  (op),
        .dec (dec)
    );

    mac_alu_arith #(.W(W)) u_arith (
        .a        (a),
        .b        (b),
        .invert_b (dec.invert_b),
        .cin      (cin),
        .sum      (arith_sum),
        .cout     (arith_cout)
    );

    mac_alu_logic #(.W(W)) u_logic (
        .a   (a),
        .b   (b),
        .lfn (dec.lfn),
        .res (logic_res)
    );

    always_comb begin
        st_d   = st_q;
        cin    = dec.use_carry ? st_q.carry : dec.const_in;
        y      = '0;
        bad_op = 1'b0;
        case (dec.cls)
            CLS_ARITH: y = arith_sum;
            CLS_LOGIC: y = logic_res;
            default: begin
                y      = '0;
                bad_op = en;
            end
        endcase
        if (clr) begin
            st_d.carry = 1'b0;
        end else if (en && dec.cls == CLS_ARITH) begin
            st_d.carry = arith_cout;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry = st_q.carry;

endmodule

// File: rtl/mac_alu_chk.sv
module mac_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         en,
    input logic [4:0]   op,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [W-1:0] y,
    input logic         carry,
    input logic         bad_op
);
    logic [W:0] add33;
    logic       is_logic;
    logic       is_hole;

    assign add33    = {1'b0, a} + {1'b0, b};
    assign is_logic = (op >= 5'd8) && (op <= 5'd12);
    assign is_hole  = ((op >= 5'd4) && (op <= 5'd7)) || (op >= 5'd13);

    // R1: add carry is the 33rd sum bit
    p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && op == 5'd0) |=> (carry == $past(add33[W])));

    // R3: subtract carry means a >= b
    p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && op == 5'd2) |=> (carry == $past(a >= b)));

    // R6: logic ops keep the flag
    p_logic_keeps_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && is_logic) |=> $stable(carry));

    // R7: holes give zero and strobe
    p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_hole) |-> (y == '0 && bad_op));

    // R7: holes keep the flag
    p_hole_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && is_hole) |=> $stable(carry));

    // R7: no strobe without a committed hole code
    p_no_stray_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && is_hole) |-> !bad_op);

    // R8: idle cycles hold the flag
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(carry));

    // R9: clear wins
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry);

endmodule

bind mac_alu mac_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (en),
    .op     (op),
    .a      (a),
    .b      (b),
    .y      (y),
    .carry  (carry),
    .bad_op (bad_op)
);

// File: tb/mac_alu_test.sv
module mac_alu_test;
    localparam int  PERIOD = 10;
    localparam int  W      = 32;
    localparam int  NRAND  = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         en = 1'b0;
    logic [4:0]   op = 5'd0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] y;
    logic         carry;
    logic         bad_op;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    bit  mcarry = 0;   // bench model of the flag

    mac_alu #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .op(op),
        .a(a), .b(b), .y(y), .carry(carry), .bad_op(bad_op)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic bit is_arith(input logic [4:0] o);
        return o <= 5'd3;
    endfunction

    function automatic bit is_logic(input logic [4:0] o);
        return o >= 5'd8 && o <= 5'd12;
    endfunction

    function automatic logic [W-1:0] exp_y(input logic [4:0] o, input logic [W-1:0] x,
                                           input logic [W-1:0] z, input bit c);
        case (o)
            5'd0:  return x + z;
            5'd1:  return x + z + W'(c);
            5'd2:  return x - z;
            5'd3:  return x - z - W'(!c);
            5'd8:  return x ^ z;
            5'd9:  return x | z;
            5'd10: return x & z;
            5'd11: return x & ~z;
            5'd12: return ~(x & z);
            default: return '0;
        endcase
    endfunction

    function automatic bit exp_c(input logic [4:0] o, input logic [W-1:0] x,
                                 input logic [W-1:0] z, input bit c);
        logic [W+1:0] wide;
        case (o)
            5'd0: begin wide = {2'b0, x} + {2'b0, z}; return wide > {2'b0, {W{1'b1}}}; end
            5'd1: begin wide = {2'b0, x} + {2'b0, z} + (W+2)'(c); return wide > {2'b0, {W{1'b1}}}; end
            5'd2: return x >= z;
            5'd3: return {2'b0, x} >= ({2'b0, z} + (W+2)'(!c));
            default: return c;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd0: return "R1";
            5'd1: return "R2";
            5'd2: return "R3";
            5'd3: return "R4";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (op=%0d a=%h b=%h)",
                     tag, what, act, exp, op, a, b);
        end
    endtask

    // One instruction: drive at negedge, check comb outputs (R10), then flag after edge.
    task automatic step(input logic [4:0] o, input logic [W-1:0] x, input logic [W-1:0] z,
                        input bit e, input bit c);
        string ctag;
        @(negedge clk);
        op = o; a = x; b = z; en = e; clr = c;
        #1;
        chk(y, exp_y(o, x, z, mcarry), tag_of(o), "y (R10 same cycle)");
        chk(W'(bad_op), W'(e && !is_arith(o) && !is_logic(o)), "R7", "bad_op");
        if (c)                    begin mcarry = 0; ctag = "R9"; end
        else if (!e)              ctag = "R8";
        else if (is_logic(o))     ctag = "R6";
        else if (is_arith(o))     begin mcarry = exp_c(o, x, z, mcarry); ctag = tag_of(o); end
        else                      ctag = "R7";
        @(posedge clk);
        #1;
        chk(W'(carry), W'(mcarry), ctag, "carry");
    endtask

    function automatic logic [W-1:0] pick();
        case ($urandom % 6)
            0: return '0;
            1: return {W{1'b1}};
            2: return W'(1);
            3: return {1'b1, {(W-1){1'b0}}};
            default: return W'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240517));
        #(PERIOD*2 + 2);
        chk(W'(carry), '0, "R9", "carry in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(W'(carry), '0, "R9", "carry after reset");

        // R1: wrap sets carry
        step(5'd0, 32'hFFFF_FFFF, 32'h1, 1, 0);
        // R8: idle holds carry=1
        step(5'd0, 32'h0, 32'h0, 0, 0);
        // R2: carry injected, wraps again
        step(5'd1, 32'hFFFF_FFFF, 32'h0, 1, 0);
        // R6: logic leaves carry=1
        step(5'd12, 32'hF0F0_1234, 32'hFF00_FF00, 1, 0);
        // R4: flag set, equal operands -> 0, no borrow
        step(5'd3, 32'h55, 32'h55, 1, 0);
        // R9: clear beats enable of a carry-setting add
        step(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
        // R4: flag clear, equal operands -> all ones, borrow
        step(5'd3, 32'h55, 32'h55, 1, 0);
        // R3: equal operands -> zero, carry 1
        step(5'd2, 32'h77, 32'h77, 1, 0);
        // R7: hole codes zero, flag kept
        step(5'd5, 32'h1234, 32'h5678, 1, 0);
        step(5'd20, 32'hFFFF, 32'h1, 1, 0);
        // R7: hole with en low, no strobe
        step(5'd4, 32'h1, 32'h1, 0, 0);
        // R3: a < b -> borrow, carry 0
        step(5'd2, 32'h1, 32'h2, 1, 0);
        // R5: each logic function
        for (int k = 8; k <= 12; k++) step(5'(k), 32'hA5A5_0FF0, 32'h3C3C_F00F, 1, 0);
        // R2: adc with flag clear, no injection
        step(5'd1, 32'h7FFF_FFFF, 32'h8000_0000, 1, 0);

        for (int n = 0; n < NRAND; n++) begin
            logic [4:0] o;
            int r = $urandom % 16;
            if (r < 4)       o = 5'(r);
            else if (r < 9)  o = 5'(r + 4);
            else             o = 5'($urandom);
            step(o, pick(), pick(), ($urandom % 5) != 0, ($urandom % 23) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD*150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule